// File: doc/BRIEF.md
# Parallel Converter Bus Controller

This block sits between a system command port and a multi-channel, simultaneous-sampling converter that talks over a shared 14-bit parallel bus. On command it writes an 8-bit configuration byte to the converter. The byte also serves as the controller's own channel-enable mask. On a separate command it raises the convert-start line so that the converter freezes all of its inputs. It then waits for the converter's active-low end-of-conversion flag and reads one result for each enabled channel, lowest channel first. Each result is returned to the host with its channel index.

The convert-start line stays high until every result has been read and a programmable minimum hold time has passed. Lowering the line both starts tracking for the next sequence and clears the flag inside the converter. If the flag does not arrive within a programmable number of cycles, the controller reports a timeout, lowers convert-start and goes back to idle. The converter's shutdown and all-channels-on pins follow two host inputs through one register stage.

Top module: `adc_host_if`

## Requirements
- R1: After reset, convert-start is low, the chip-select, read and write strobes (all active low) are high, and `busy`, `respValid`, `errTimeout`, `adcShdn` and `adcAllOn` are all 0.
- R2: `cmdWrCfg` in idle stores `cfgByte` and holds chip-select and write low for WR_CYC cycles. During that time `cfgByte` is driven on bus bits 7:0 and bus bits 13:8 are driven with zeros.
- R3: `cmdStart` in idle raises convert-start. The line stays high for at least `cfgHold` cycles, stays high throughout every read strobe, and falls only after the last result of the sequence has been delivered. When the reads finish before `cfgHold`, the line is high for exactly `cfgHold` cycles.
- R4: Once `adcEolcN` is low, exactly one read is made for each enabled channel, in ascending channel order. Channel i is enabled when bit i of the stored configuration byte is 1, or in every case when `adcAllOn` is 1. Each read delivers a one-cycle `respValid` pulse carrying the 14-bit bus word on `respData` and the 3-bit channel index on `respChan`.
- R5: The read and write strobes are never low in the same cycle, and the controller never drives the bus while the read strobe is low.
- R6: A read strobe never begins in the cycle right after a cycle in which the write strobe was low. Consecutive read strobes are separated by at least one cycle with the read strobe high.
- R7: The timeout counter counts cycles from the rise of convert-start, starting at 0 in the first high cycle. If `adcEolcN` is still high in the cycle where the count equals `cfgTimeout`, `errTimeout` pulses for one cycle, convert-start falls in that same cycle, no reads are made, and the block returns to idle. A flag that is low in that cycle counts as in time.
- R8: `adcShdn` and `adcAllOn` follow `hostShutdown` and `hostAllOn` one clock later.
- R9: `cmdWrCfg` and `cmdStart` are ignored while `busy` is 1. The stored configuration is not changed, no write strobe is issued and no second sequence starts.
- R10: With no channel enabled, a conversion still raises and holds convert-start, then lowers it with no read strobe and no `respValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdWrCfg | input | 1 | Request a configuration write (taken in idle) |
| cmdStart | input | 1 | Request a conversion sequence (taken in idle) |
| cfgByte | input | 8 | Configuration byte; bit i enables channel i |
| cfgHold | input | CNT_W | Minimum convert-start high time in cycles |
| cfgTimeout | input | CNT_W | Timeout count for the end-of-conversion flag |
| hostShutdown | input | 1 | Requested level of the shutdown pin |
| hostAllOn | input | 1 | Requested level of the all-channels pin |
| busy | output | 1 | A write or a conversion sequence is in progress |
| errTimeout | output | 1 | One-cycle pulse on a timeout |
| respValid | output | 1 | One-cycle pulse with each result |
| respChan | output | 3 | Channel index of the result |
| respData | output | DATA_W | Result word |
| adcConvst | output | 1 | Convert-start line to the converter |
| adcEolcN | input | 1 | Active-low end-of-last-conversion flag |
| adcCsN | output | 1 | Active-low chip-select |
| adcRdN | output | 1 | Active-low read strobe |
| adcWrN | output | 1 | Active-low write strobe |
| adcD | inout | DATA_W | Shared bidirectional data bus |
| adcShdn | output | 1 | Shutdown pin |
| adcAllOn | output | 1 | All-channels-enabled pin |

## Verification
The arrival of the end-of-conversion flag and the expiry of the timeout can land in the same cycle. Both are settled by one decision in the waiting state. To provoke the tie, the bench sets the converter model's flag latency so that the flag first reads low in exactly the cycle where the count equals `cfgTimeout`, and then sets it one cycle later. The first case must produce a normal read with no `errTimeout`. The second must produce one `errTimeout` pulse, no results and convert-start back low.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;
  localparam int CH_N  = 8;
  localparam int CH_W  = 3;
  localparam int CFG_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WRITE, ST_WTURN, ST_HOLD, ST_RSTRB, ST_RGAP, ST_FINISH
  } hostState_t;

  typedef struct packed {
    logic            latchCfg;
    logic            driveBus;
    logic            capture;
    logic [CH_W-1:0] chan;
    logic [CH_W:0]   searchFrom;
  } adcStrobe_t;
endpackage

// File: rtl/adcHostCtrl.sv
module adcHostCtrl
  import adc_host_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int WR_CYC = 2,
  parameter int RD_CYC = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdWrCfg,
  input  logic             cmdStart,
  input  logic [CNT_W-1:0] cfgHold,
  input  logic [CNT_W-1:0] cfgTimeout,
  input  logic             adcEolcN,
  input  logic             nextFound,
  input  logic [CH_W-1:0]  nextIdx,
  output adcStrobe_t       strb,
  output logic             adcConvst,
  output logic             adcCsN,
  output logic             adcRdN,
  output logic             adcWrN,
  output logic             busy,
  output logic             errTimeout
);
  localparam int PH_MAX = (WR_CYC > RD_CYC) ? WR_CYC : RD_CYC;
  localparam int PH_W   = $clog2(PH_MAX + 1);

  hostState_t       state;
  logic [PH_W-1:0]  phCnt;
  logic [CNT_W-1:0] seqCnt;
  logic [CNT_W-1:0] seqInc;
  logic [CH_W-1:0]  curChan;
  logic             wrLast, rdLast, holdMet;

  assign seqInc  = (seqCnt == {CNT_W{1'b1}}) ? seqCnt : seqCnt + 1'b1;
  assign wrLast  = (phCnt == PH_W'(WR_CYC - 1));
  assign rdLast  = (phCnt == PH_W'(RD_CYC - 1));
  assign holdMet = ({1'b0, seqCnt} + 1'b1) >= {1'b0, cfgHold};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      phCnt      <= '0;
      seqCnt     <= '0;
      curChan    <= '0;
      adcConvst  <= 1'b0;
      errTimeout <= 1'b0;
    end else begin
      errTimeout <= 1'b0;
      case (state)
        ST_IDLE: begin
          phCnt <= '0;
          if (cmdWrCfg) begin
            state <= ST_WRITE;
          end else if (cmdStart) begin
            state     <= ST_HOLD;
            adcConvst <= 1'b1;
            seqCnt    <= '0;
          end
        end
        ST_WRITE: begin
          if (wrLast) begin
            phCnt <= '0;
            state <= ST_WTURN;
          end else begin
            phCnt <= phCnt + 1'b1;
          end
        end
        ST_WTURN: state <= ST_IDLE;
        ST_HOLD: begin
          seqCnt <= seqInc;
          if (!adcEolcN) begin
            if (nextFound) begin
              curChan <= nextIdx;
              state   <= ST_RSTRB;
            end else begin
              state <= ST_FINISH;
            end
          end else if (seqCnt >= cfgTimeout) begin
            errTimeout <= 1'b1;
            adcConvst  <= 1'b0;
            state      <= ST_IDLE;
          end
        end
        ST_RSTRB: begin
          seqCnt <= seqInc;
          if (rdLast) begin
            phCnt <= '0;
            state <= ST_RGAP;
          end else begin
            phCnt <= phCnt + 1'b1;
          end
        end
        ST_RGAP: begin
          seqCnt <= seqInc;
          if (nextFound) begin
            curChan <= nextIdx;
            state   <= ST_RSTRB;
          end else begin
            state <= ST_FINISH;
          end
        end
        ST_FINISH: begin
          seqCnt <= seqInc;
          if (holdMet) begin
            adcConvst <= 1'b0;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.latchCfg   = (state == ST_IDLE) && cmdWrCfg;
    strb.driveBus   = (state == ST_WRITE);
    strb.capture    = (state == ST_RSTRB) && rdLast;
    strb.chan       = curChan;
    strb.searchFrom = (state == ST_HOLD) ? '0 : {1'b0, curChan} + 1'b1;
  end

  assign adcCsN = !((state == ST_WRITE) || (state == ST_RSTRB));
  assign adcWrN = !(state == ST_WRITE);
  assign adcRdN = !(state == ST_RSTRB);
  assign busy   = (state != ST_IDLE);
endmodule

// File: rtl/adcHostData.sv
module adcHostData
  import adc_host_pkg::*;
#(
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  adcStrobe_t        strb,
  input  logic [CFG_W-1:0]  cfgByte,
  input  logic              hostShutdown,
  input  logic              hostAllOn,
  input  logic [DATA_W-1:0] busIn,
  output logic [DATA_W-1:0] busOut,
  output logic              driveEn,
  output logic              nextFound,
  output logic [CH_W-1:0]   nextIdx,
  output logic              respValid,
  output logic [CH_W-1:0]   respChan,
  output logic [DATA_W-1:0] respData,
  output logic              adcShdn,
  output logic              adcAllOn
);
  logic [CFG_W-1:0] cfgReg;
  logic [CH_N-1:0]  chanMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg    <= '0;
      respValid <= 1'b0;
      respChan  <= '0;
      respData  <= '0;
      adcShdn   <= 1'b0;
      adcAllOn  <= 1'b0;
    end else begin
      adcShdn   <= hostShutdown;
      adcAllOn  <= hostAllOn;
      respValid <= strb.capture;
      if (strb.latchCfg) cfgReg <= cfgByte;
      if (strb.capture) begin
        respData <= busIn;
        respChan <= strb.chan;
      end
    end
  end

  assign chanMask = adcAllOn ? {CH_N{1'b1}} : cfgReg[CH_N-1:0];

  always_comb begin
    nextFound = 1'b0;
    nextIdx   = '0;
    for (int i = CH_N - 1; i >= 0; i--) begin
      if (chanMask[i] && (i >= int'(strb.searchFrom))) begin
        nextFound = 1'b1;
        nextIdx   = CH_W'(i);
      end
    end
  end

  assign busOut  = {{(DATA_W - CFG_W){1'b0}}, cfgReg};
  assign driveEn = strb.driveBus;
endmodule

// File: rtl/adc_host_if.sv
module adc_host_if
  import adc_host_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int CNT_W  = 16,
  parameter int WR_CYC = 2,
  parameter int RD_CYC = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWrCfg,
  input  logic              cmdStart,
  input  logic [7:0]        cfgByte,
  input  logic [CNT_W-1:0]  cfgHold,
  input  logic [CNT_W-1:0]  cfgTimeout,
  input  logic              hostShutdown,
  input  logic              hostAllOn,
  output logic              busy,
  output logic              errTimeout,
  output logic              respValid,
  output logic [2:0]        respChan,
  output logic [DATA_W-1:0] respData,
  output logic              adcConvst,
  input  logic              adcEolcN,
  output logic              adcCsN,
  output logic              adcRdN,
  output logic              adcWrN,
  inout  wire  [DATA_W-1:0] adcD,
  output logic              adcShdn,
  output logic              adcAllOn
);
  adcStrobe_t        strb;
  logic              nextFound;
  logic [CH_W-1:0]   nextIdx;
  logic [DATA_W-1:0] busOut;
  logic              driveEn;

  adcHostCtrl #(.CNT_W(CNT_W), .WR_CYC(WR_CYC), .RD_CYC(RD_CYC)) uCtrl (
    .clk(clk), .rstN(rstN), .cmdWrCfg(cmdWrCfg), .cmdStart(cmdStart),
    .cfgHold(cfgHold), .cfgTimeout(cfgTimeout), .adcEolcN(adcEolcN),
    .nextFound(nextFound), .nextIdx(nextIdx), .strb(strb),
    .adcConvst(adcConvst), .adcCsN(adcCsN), .adcRdN(adcRdN), .adcWrN(adcWrN),
    .busy(busy), .errTimeout(errTimeout)
  );

  adcHostData #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgByte(cfgByte),
    .hostShutdown(hostShutdown), .hostAllOn(hostAllOn), .busIn(adcD),
    .busOut(busOut), .driveEn(driveEn), .nextFound(nextFound), .nextIdx(nextIdx),
    .respValid(respValid), .respChan(respChan), .respData(respData),
    .adcShdn(adcShdn), .adcAllOn(adcAllOn)
  );

  assign adcD = driveEn ? busOut : {DATA_W{1'bz}};
endmodule

// File: rtl/adcHostChecker.sv
module adcHostChecker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             convst,
  input logic             rdN,
  input logic             wrN,
  input logic             driveEn,
  input logic             errTimeout,
  input logic             respValid,
  input logic [2:0]       respChan,
  input logic [CNT_W-1:0] cfgHold
);
  logic [CNT_W:0] hiCnt;
  logic           haveLast;
  logic [2:0]     lastChan;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiCnt    <= '0;
      haveLast <= 1'b0;
      lastChan <= '0;
    end else begin
      hiCnt <= convst ? hiCnt + 1'b1 : '0;
      if (!convst) begin
        haveLast <= 1'b0;
      end else if (respValid) begin
        haveLast <= 1'b1;
        lastChan <= respChan;
      end
    end
  end

  assert_rd_wr_exclusive_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdN && !wrN));
  assert_bus_released_R5: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> !driveEn);
  assert_turnaround_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdN) |-> $past(wrN));
  assert_read_in_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> convst);
  assert_hold_min_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(convst) && !errTimeout) |-> (hiCnt >= {1'b0, cfgHold}));
  assert_timeout_drops_R7: assert property (@(posedge clk) disable iff (!rstN)
    errTimeout |-> !convst);
  assert_chan_ascending_R4: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && haveLast && convst) |-> (respChan > lastChan));
endmodule

bind adc_host_if adcHostChecker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .convst(adcConvst), .rdN(adcRdN), .wrN(adcWrN),
  .driveEn(driveEn), .errTimeout(errTimeout), .respValid(respValid),
  .respChan(respChan), .cfgHold(cfgHold)
);

// File: tb/sim_adc_host_if.sv
module sim_adc_host_if;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdWrCfg = 1'b0, cmdStart = 1'b0;
  logic [7:0]  cfgByte = '0;
  logic [15:0] cfgHold = 16'd12, cfgTimeout = 16'd30;
  logic        hostShutdown = 1'b0, hostAllOn = 1'b0;
  logic        busy, errTimeout, respValid;
  logic [2:0]  respChan;
  logic [13:0] respData;
  logic        convst, csN, rdN, wrN, shdn, allOn;
  logic        mEolcN;
  tri   [13:0] adcD;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  adc_host_if u0 (
    .clk(clk), .rstN(rstN), .cmdWrCfg(cmdWrCfg), .cmdStart(cmdStart),
    .cfgByte(cfgByte), .cfgHold(cfgHold), .cfgTimeout(cfgTimeout),
    .hostShutdown(hostShutdown), .hostAllOn(hostAllOn), .busy(busy),
    .errTimeout(errTimeout), .respValid(respValid), .respChan(respChan),
    .respData(respData), .adcConvst(convst), .adcEolcN(mEolcN), .adcCsN(csN),
    .adcRdN(rdN), .adcWrN(wrN), .adcD(adcD), .adcShdn(shdn), .adcAllOn(allOn)
  );

  function automatic logic [13:0] expData(int s, int c);
    logic [31:0] v;
    v = s * 977 + c * 131 + 5;
    return v[13:0];
  endfunction

  // ---------------- behavioural converter model ----------------
  logic [13:0] mCfgWord = '0;
  int          mWrCount = 0, mSeq = 0, mCnt = 0, mPtr = 0, mLat = 2;
  logic        prevConv = 1'b0, prevRd = 1'b1, prevWr = 1'b1;
  logic [7:0]  mMask;
  int          mChan;
  logic [13:0] mWord;

  always_comb begin
    mMask = allOn ? 8'hFF : mCfgWord[7:0];
    mChan = 7;
    for (int i = 7; i >= 0; i--) if (mMask[i] && i >= mPtr) mChan = i;
    mWord = expData(mSeq, mChan);
  end

  assign adcD = (!csN && !rdN) ? mWord : 14'bz;

  initial mEolcN = 1'b1;
  always @(posedge clk) begin
    if (!csN && !wrN) mCfgWord <= adcD;
    if (wrN && !prevWr) mWrCount <= mWrCount + 1;
    if (convst && !prevConv) begin mSeq <= mSeq + 1; mPtr <= 0; end
    else if (rdN && !prevRd) mPtr <= mChan + 1;
    if (!convst) begin mCnt <= 0; mEolcN <= 1'b1; end
    else if (mCnt == mLat) mEolcN <= 1'b0;
    else mCnt <= mCnt + 1;
    prevConv <= convst; prevRd <= rdN; prevWr <= wrN;
  end

  // ---------------- monitors (sampled at negedge) ----------------
  int   cyc = 0, rCnt = 0, errCnt = 0, lastRespCyc = 0, fallCyc = 0;
  int   hiLen = 0, lastHi = 0, viol5 = 0, viol6 = 0;
  int   rChan [8];
  int   rData [8];
  logic nPrevWrLow = 1'b0, nPrevConv = 1'b0, nPrevRdLow = 1'b0;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rstN) begin
      if (respValid) begin
        if (rCnt < 8) begin rChan[rCnt] <= respChan; rData[rCnt] <= respData; end
        rCnt <= rCnt + 1;
        lastRespCyc <= cyc;
      end
      if (errTimeout) errCnt <= errCnt + 1;
      if (convst) hiLen <= nPrevConv ? hiLen + 1 : 1;
      if (!convst && nPrevConv) begin lastHi <= hiLen; fallCyc <= cyc; end
      if (!rdN && !wrN) viol5 <= viol5 + 1;
      if (!rdN && !nPrevRdLow && nPrevWrLow) viol6 <= viol6 + 1;
    end
    nPrevWrLow <= !wrN; nPrevConv <= convst; nPrevRdLow <= !rdN;
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic waitIdle();
    int g = 0;
    @(negedge clk);
    while (busy && g < 3000) begin @(negedge clk); g++; end
  endtask

  task automatic doWrite(logic [7:0] b);
    @(negedge clk); cmdWrCfg = 1'b1; cfgByte = b;
    @(negedge clk); cmdWrCfg = 1'b0;
    waitIdle();
  endtask

  int startCount = 0;
  task automatic doStart();
    @(negedge clk); cmdStart = 1'b1;
    @(negedge clk); cmdStart = 1'b0;
    startCount++;
    waitIdle();
    repeat (2) @(negedge clk);
  endtask

  task automatic clearMon();
    @(negedge clk);
    rCnt = 0; errCnt = 0; viol5 = 0; viol6 = 0; lastHi = 0;
  endtask

  // cfg[20:13] allOn[12] latency[11:4] expected reads[3:0]
  localparam logic [20:0] VECS [0:5] = '{
    {8'hA5, 1'b0, 8'd3, 4'd4},
    {8'h01, 1'b0, 8'd0, 4'd1},
    {8'h80, 1'b0, 8'd5, 4'd1},
    {8'h00, 1'b1, 8'd2, 4'd8},
    {8'h00, 1'b0, 8'd2, 4'd0},
    {8'h5A, 1'b0, 8'd1, 4'd4}
  };

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(convst == 1'b0, "R1", "convst", convst, 0);
    chk(csN && rdN && wrN, "R1", "strobes high", {csN, rdN, wrN}, 7);
    chk(!busy && !respValid && !errTimeout, "R1", "busy/resp/err", {busy, respValid, errTimeout}, 0);
    chk(!shdn && !allOn, "R1", "shdn/allOn", {shdn, allOn}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // vector table walk
    for (int v = 0; v < 6; v++) begin
      logic [7:0] c;
      logic [7:0] mask;
      int k;
      c = VECS[v][20:13];
      hostAllOn = VECS[v][12];
      mLat = int'(VECS[v][11:4]);
      repeat (2) @(negedge clk);
      doWrite(c);
      chk(mCfgWord == {6'b0, c}, "R2", "written bus word", mCfgWord, {6'b0, c});
      clearMon();
      doStart();
      mask = hostAllOn ? 8'hFF : c;
      chk(rCnt == int'(VECS[v][3:0]), mask == 0 ? "R10" : "R4", "read count", rCnt, VECS[v][3:0]);
      k = 0;
      for (int ch = 0; ch < 8; ch++) begin
        if (mask[ch] && k < 8) begin
          chk(rChan[k] == ch, "R4", "channel order", rChan[k], ch);
          chk(rData[k] == int'(expData(startCount, ch)), "R4", "result word", rData[k], expData(startCount, ch));
          k++;
        end
      end
      chk(viol5 == 0, "R5", "rd/wr overlap cycles", viol5, 0);
      chk(viol6 == 0, "R6", "read right after write", viol6, 0);
      chk(lastHi >= 12, "R3", "convst high cycles", lastHi, 12);
      if (rCnt > 0) chk(fallCyc > lastRespCyc, "R3", "convst fall after last result", fallCyc, lastRespCyc + 1);
      chk(errCnt == 0, "R7", "no spurious timeout", errCnt, 0);
    end
    hostAllOn = 1'b0;

    // R3 exact hold when reads finish early
    cfgHold = 16'd40; mLat = 1;
    doWrite(8'h01);
    clearMon();
    doStart();
    chk(lastHi == 40, "R3", "convst high exactly hold", lastHi, 40);
    chk(rCnt == 1, "R4", "single channel read", rCnt, 1);
    cfgHold = 16'd12;

    // R7 boundary: flag low exactly at count == timeout is in time
    cfgTimeout = 16'd10; mLat = 9;
    clearMon();
    doStart();
    chk(errCnt == 0, "R7", "flag at limit no error", errCnt, 0);
    chk(rCnt == 1, "R7", "flag at limit reads", rCnt, 1);
    // one cycle later: timeout
    mLat = 10;
    clearMon();
    doStart();
    chk(errCnt == 1, "R7", "timeout pulse count", errCnt, 1);
    chk(rCnt == 0, "R7", "no reads on timeout", rCnt, 0);
    chk(!convst && !busy, "R7", "idle after timeout", {convst, busy}, 0);
    chk(lastHi == 11, "R7", "convst high cycles on timeout", lastHi, 11);
    cfgTimeout = 16'd30; mLat = 2;

    // R9 commands ignored while busy
    begin
      int wrBefore;
      wrBefore = mWrCount;
      clearMon();
      @(negedge clk); cmdStart = 1'b1;
      @(negedge clk); cmdStart = 1'b0; startCount++;
      @(negedge clk); cmdWrCfg = 1'b1; cfgByte = 8'h3C; cmdStart = 1'b1;
      @(negedge clk); cmdWrCfg = 1'b0; cmdStart = 1'b0;
      waitIdle();
      repeat (4) @(negedge clk);
      chk(busy == 1'b0, "R9", "no second sequence", busy, 0);
      chk(mWrCount == wrBefore, "R9", "write strobes while busy", mWrCount, wrBefore);
      chk(mCfgWord[7:0] == 8'h01, "R9", "config unchanged", mCfgWord[7:0], 8'h01);
      chk(rCnt == 1, "R9", "reads with old mask", rCnt, 1);
      doStart();
      chk(rCnt == 2 && rChan[1] == 0, "R9", "stored mask still in use", rCnt, 2);
    end

    // R8 pin pass-through with one cycle latency
    @(negedge clk); hostShutdown = 1'b1; hostAllOn = 1'b1;
    chk(!shdn && !allOn, "R8", "pins before edge", {shdn, allOn}, 0);
    @(negedge clk);
    chk(shdn && allOn, "R8", "pins after one clock", {shdn, allOn}, 3);
    hostShutdown = 1'b0; hostAllOn = 1'b0;
    @(negedge clk);
    chk(!shdn && !allOn, "R8", "pins released", {shdn, allOn}, 0);

    summary();
  end
endmodule